// File: doc/BRIEF.md
# Vector Sum-Reduction Sequencer

The block folds one fixed-size vector register into a single scalar sum. The program picks the element size (8, 16 or 32 bits) with each request. With the vector byte count fixed, that choice sets the lane count N. The block then runs log2(N) stages. Each stage takes two clocks. First an interleave step pairs the vector with itself: the low-half lanes are spread into even and odd positions of one vector, and the high-half lanes into another. A lane-wise wrapping add of those two vectors follows. The interleave pattern does not depend on N, so the same sequence serves every lane count. After the last stage every lane holds the total, and the block reports the last lane.

Each lane carries two metadata bits: a NaR flag, and a payload bit that marks the NaR as the None kind. The block poisons the result from these bits, and None takes precedence over NaR. An optional mode treats None lanes as zero-valued ordinary lanes, so that None acts as the identity of the sum.

Top module: `vred_sum_seq`

## Requirements
- R1: After reset, done_o is low, and it stays low until a start is accepted.
- R2: esize_i selects the element width: 2'b00 gives 8 bits, 2'b01 gives 16 bits, 2'b10 and 2'b11 give 32 bits. The lane count is N = VEC_BYTES*8/width, so 16, 8 or 4 lanes at the default 16 bytes. Lane i occupies vec_i bits [i*width +: width].
- R3: result_o is the sum of the data of lanes 0..N-1 modulo 2^width, zero-extended to 32 bits. The poison flags do not alter the data.
- R4: done_o is high in the cycle that begins 2*log2(N) rising edges after the edge that accepts start_i.
- R5: done_o is high for exactly one cycle. result_o, res_nar_o and res_none_o hold their values until the next accepted start.
- R6: A start_i seen from the accepting edge up to and including the done cycle is ignored. It neither restarts the sequence nor produces an extra done_o.
- R7: A lane is None when lane_nar_i and lane_none_i are both set. If any lane 0..N-1 is None, res_nar_o = 1 and res_none_o = 1.
- R8: Otherwise, if any lane 0..N-1 has lane_nar_i set, res_nar_o = 1 and res_none_o = 0. Otherwise both are 0. lane_none_i without lane_nar_i marks an ordinary lane.
- R9: Metadata bits of lane index N and above have no effect on the result.
- R10: With zero_none_i set at the accepting edge, each None lane counts as data zero and as an ordinary lane. Non-None NaR lanes still poison the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| zero_none_i | input | 1 | Treat None lanes as zero |
| esize_i | input | 2 | Element width select |
| vec_i | input | VEC_BYTES*8 | Source vector |
| lane_nar_i | input | VEC_BYTES | Per-lane NaR flag |
| lane_none_i | input | VEC_BYTES | Per-lane None payload bit |
| done_o | output | 1 | One-cycle result-valid strobe |
| result_o | output | 32 | Scalar sum, zero-extended |
| res_nar_o | output | 1 | Result is NaR |
| res_none_o | output | 1 | Result is the None kind of NaR |

## Verification
The assertions assume that rst_n is held low for at least one rising edge before the first request. They also assume that esize_i and zero_none_i are valid whenever start_i is sampled, because the checker latches its own copy of both at the accepting edge. The stimulus drives all inputs half a cycle away from the rising edge. It raises start_i only once reset has been released, and it sweeps every esize_i code, including the reserved one. Random metadata is drawn across the full lane range, so that bits above N are exercised as well.

// File: rtl/vred_pkg.sv
// Shared types and helpers for the vector sum-reduction sequencer.
// Assumes element widths of 1, 2 or 4 bytes, held as log2 of the byte count.
package vred_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHUF = 2'd1,
        ST_ADD  = 2'd2,
        ST_DONE = 2'd3
    } vred_state_e;

    // Map the external size select onto log2(bytes per element).
    function automatic logic [1:0] esize_to_log(input logic [1:0] sel);
        case (sel)
            2'b00:   esize_to_log = 2'd0;
            2'b01:   esize_to_log = 2'd1;
            default: esize_to_log = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/vred_interleave.sv
// Interleave primitive: lo = {a0,b0,a1,b1,...} taken from the low half of the
// lanes, hi = the same pattern taken from the high half.
// Assumes VEC_BYTES is a power of two and esz_log selects 1/2/4-byte lanes.
module vred_interleave #(
    parameter int VEC_BYTES = 16
) (
    input  logic [VEC_BYTES*8-1:0] a_i,
    input  logic [VEC_BYTES*8-1:0] b_i,
    input  logic [1:0]             esz_log_i,
    output logic [VEC_BYTES*8-1:0] lo_o,
    output logic [VEC_BYTES*8-1:0] hi_o
);
    localparam int HALF = VEC_BYTES / 2;

    // Byte-level routing: destination lane j draws source lane j/2 (or its mirror in the high half).
    always_comb begin
        lo_o = '0;
        hi_o = '0;
        for (int p = 0; p < VEC_BYTES; p++) begin
            int lane;
            int off;
            int src;
            lane = p >> esz_log_i;
            off  = p & ((1 << esz_log_i) - 1);
            src  = ((lane >> 1) << esz_log_i) + off;
            if ((lane & 1) == 0) begin
                lo_o[p*8 +: 8] = a_i[src*8 +: 8];
                hi_o[p*8 +: 8] = a_i[(src+HALF)*8 +: 8];
            end else begin
                lo_o[p*8 +: 8] = b_i[src*8 +: 8];
                hi_o[p*8 +: 8] = b_i[(src+HALF)*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/vred_lane_add.sv
// Lane-wise wrapping adder: byte adders whose carry chain is cut at each
// element boundary chosen by esz_log_i.
// Assumes element sizes of 1, 2 or 4 bytes.
module vred_lane_add #(
    parameter int VEC_BYTES = 16
) (
    input  logic [VEC_BYTES*8-1:0] x_i,
    input  logic [VEC_BYTES*8-1:0] y_i,
    input  logic [1:0]             esz_log_i,
    output logic [VEC_BYTES*8-1:0] sum_o
);
    // Ripple the carry through each element; drop it at lane starts.
    always_comb begin
        logic       cy;
        logic [8:0] part;
        cy    = 1'b0;
        sum_o = '0;
        for (int p = 0; p < VEC_BYTES; p++) begin
            if ((p & ((1 << esz_log_i) - 1)) == 0) cy = 1'b0;
            part = {1'b0, x_i[p*8 +: 8]} + {1'b0, y_i[p*8 +: 8]} + {8'd0, cy};
            sum_o[p*8 +: 8] = part[7:0];
            cy = part[8];
        end
    end

endmodule

// File: rtl/vred_meta_screen.sv
// Screens per-lane metadata at request time: reduces the poison flags over
// the active lanes, and zeroes None lanes when the identity mode is chosen.
// Assumes lane_none_i is only meaningful where lane_nar_i is set.
module vred_meta_screen #(
    parameter int VEC_BYTES = 16
) (
    input  logic [VEC_BYTES*8-1:0] vec_i,
    input  logic [VEC_BYTES-1:0]   nar_i,
    input  logic [VEC_BYTES-1:0]   none_i,
    input  logic [1:0]             esz_log_i,
    input  logic                   zero_none_i,
    output logic [VEC_BYTES*8-1:0] vec_o,
    output logic                   any_nar_o,
    output logic                   any_none_o
);
    localparam int LANES_MAX = VEC_BYTES;

    logic [LANES_MAX-1:0] is_none;
    logic [LANES_MAX-1:0] active;

    // Classify each lane slot and flag the ones inside the current lane count.
    always_comb begin
        for (int l = 0; l < LANES_MAX; l++) begin
            is_none[l] = nar_i[l] & none_i[l];
            active[l]  = (l < (VEC_BYTES >> esz_log_i));
        end
    end

    // OR-reduce the poison over active lanes; None may be turned into an ordinary zero.
    always_comb begin
        any_nar_o  = 1'b0;
        any_none_o = 1'b0;
        for (int l = 0; l < LANES_MAX; l++) begin
            if (active[l]) begin
                if (is_none[l] && !zero_none_i) any_none_o = 1'b1;
                if (nar_i[l] && !(is_none[l] && zero_none_i)) any_nar_o = 1'b1;
            end
        end
    end

    // Replace the data bytes of None lanes with zero in identity mode.
    always_comb begin
        for (int p = 0; p < VEC_BYTES; p++) begin
            if (zero_none_i && is_none[p >> esz_log_i]) vec_o[p*8 +: 8] = 8'd0;
            else                                        vec_o[p*8 +: 8] = vec_i[p*8 +: 8];
        end
    end

endmodule

// File: rtl/vred_sum_seq.sv
// Sum-reduction sequencer: log2(N) stages, each an interleave clock followed
// by a lane-wise add clock; the last lane then holds the total.
// Assumes VEC_BYTES is a power of two and at least 8.
module vred_sum_seq
    import vred_pkg::*;
#(
    parameter int VEC_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   zero_none_i,
    input  logic [1:0]             esize_i,
    input  logic [VEC_BYTES*8-1:0] vec_i,
    input  logic [VEC_BYTES-1:0]   lane_nar_i,
    input  logic [VEC_BYTES-1:0]   lane_none_i,
    output logic                   done_o,
    output logic [31:0]            result_o,
    output logic                   res_nar_o,
    output logic                   res_none_o
);
    localparam int VEC_W     = VEC_BYTES * 8;
    localparam int LOG_BYTES = $clog2(VEC_BYTES);
    localparam int STG_W     = $clog2(LOG_BYTES + 1);

    vred_state_e      state_q;
    logic [1:0]       esz_q;
    logic [STG_W-1:0] stg_q;
    logic [VEC_W-1:0] v_q;
    logic [VEC_W-1:0] lo_q;
    logic [VEC_W-1:0] hi_q;
    logic             nar_q;
    logic             none_q;

    logic [1:0]       esz_in;
    logic [VEC_W-1:0] vec_screened;
    logic             any_nar;
    logic             any_none;
    logic [VEC_W-1:0] lo_d;
    logic [VEC_W-1:0] hi_d;
    logic [VEC_W-1:0] sum_d;
    logic             accept;
    logic             busy;

    // Decode the size select and decide whether a request is taken.
    assign esz_in = esize_to_log(esize_i);
    assign accept = start_i && (state_q == ST_IDLE);
    assign busy   = (state_q != ST_IDLE);

    vred_meta_screen #(.VEC_BYTES(VEC_BYTES)) u_screen (
        .vec_i       (vec_i),
        .nar_i       (lane_nar_i),
        .none_i      (lane_none_i),
        .esz_log_i   (esz_in),
        .zero_none_i (zero_none_i),
        .vec_o       (vec_screened),
        .any_nar_o   (any_nar),
        .any_none_o  (any_none)
    );

    vred_interleave #(.VEC_BYTES(VEC_BYTES)) u_ilv (
        .a_i       (v_q),
        .b_i       (v_q),
        .esz_log_i (esz_q),
        .lo_o      (lo_d),
        .hi_o      (hi_d)
    );

    vred_lane_add #(.VEC_BYTES(VEC_BYTES)) u_add (
        .x_i       (lo_q),
        .y_i       (hi_q),
        .esz_log_i (esz_q),
        .sum_o     (sum_d)
    );

    // Sequencer: capture on accept, alternate interleave and add, then pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            esz_q   <= '0;
            stg_q   <= '0;
            v_q     <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            nar_q   <= 1'b0;
            none_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_SHUF;
                        esz_q   <= esz_in;
                        stg_q   <= STG_W'(LOG_BYTES - int'(esz_in));
                        v_q     <= vec_screened;
                        nar_q   <= any_nar;
                        none_q  <= any_none;
                    end
                end
                ST_SHUF: begin
                    lo_q    <= lo_d;
                    hi_q    <= hi_d;
                    state_q <= ST_ADD;
                end
                ST_ADD: begin
                    v_q   <= sum_d;
                    stg_q <= stg_q - 1'b1;
                    if (stg_q == STG_W'(1)) state_q <= ST_DONE;
                    else                    state_q <= ST_SHUF;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Pull the last lane out as a zero-extended scalar.
    always_comb begin
        case (esz_q)
            2'd0:    result_o = {24'd0, v_q[VEC_W-1 -: 8]};
            2'd1:    result_o = {16'd0, v_q[VEC_W-1 -: 16]};
            default: result_o = v_q[VEC_W-1 -: 32];
        endcase
    end

    // Status outputs from held state.
    assign done_o     = (state_q == ST_DONE);
    assign res_nar_o  = nar_q;
    assign res_none_o = none_q;

endmodule

// File: rtl/vred_sum_seq_chk.sv
// Checker for vred_sum_seq: latency, strobe shape, busy behaviour and
// poison encoding. Keeps its own copy of the request size and mode.
// Assumes rst_n is low for at least one edge before the first request.
module vred_sum_seq_chk #(
    parameter int VEC_BYTES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        zero_none_i,
    input logic [1:0]  esize_i,
    input logic        busy_i,
    input logic [1:0]  esz_q_i,
    input logic        done_o,
    input logic [31:0] result_o,
    input logic        res_nar_o,
    input logic        res_none_o
);
    localparam int LOG_BYTES = $clog2(VEC_BYTES);

    logic [1:0] esz_c;
    logic       zero_c;
    logic [7:0] cyc;
    logic [7:0] exp_cyc;

    // Track the request: its size, mode and the cycles elapsed since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esz_c  <= '0;
            zero_c <= 1'b0;
            cyc    <= '0;
        end else if (start_i && !busy_i) begin
            esz_c  <= (esize_i == 2'b00) ? 2'd0 : (esize_i == 2'b01) ? 2'd1 : 2'd2;
            zero_c <= zero_none_i;
            cyc    <= '0;
        end else if (busy_i) begin
            cyc <= cyc + 8'd1;
        end
    end

    assign exp_cyc = 8'(2 * (LOG_BYTES - int'(esz_c)));

    // R4: done appears after two clocks per stage
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc == exp_cyc));

    // R5: done is a single-cycle strobe
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: outputs hold while idle and no request arrives
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !start_i) |=> $stable({result_o, res_nar_o, res_none_o}));

    // R6: a start during a sequence neither ends it nor changes its size
    a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_o && start_i) |=> (busy_i && $stable(esz_q_i)));

    // R7: None is a kind of NaR
    a_r7_none_is_nar: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!res_none_o || res_nar_o));

    // R10: identity mode never yields None
    a_r10_zero_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zero_c) |-> !res_none_o);

endmodule

bind vred_sum_seq vred_sum_seq_chk #(.VEC_BYTES(VEC_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .zero_none_i (zero_none_i),
    .esize_i     (esize_i),
    .busy_i      (busy),
    .esz_q_i     (esz_q),
    .done_o      (done_o),
    .result_o    (result_o),
    .res_nar_o   (res_nar_o),
    .res_none_o  (res_none_o)
);

// File: tb/vred_sum_seq_tb.sv
module vred_sum_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VB = 16;
    localparam int VW = VB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          zero_none_i = 1'b0;
    logic [1:0]    esize_i = 2'b00;
    logic [VW-1:0] vec_i = '0;
    logic [VB-1:0] lane_nar_i = '0;
    logic [VB-1:0] lane_none_i = '0;
    logic          done_o;
    logic [31:0]   result_o;
    logic          res_nar_o;
    logic          res_none_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    vred_sum_seq #(.VEC_BYTES(VB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero_none_i(zero_none_i),
        .esize_i(esize_i), .vec_i(vec_i), .lane_nar_i(lane_nar_i),
        .lane_none_i(lane_none_i), .done_o(done_o), .result_o(result_o),
        .res_nar_o(res_nar_o), .res_none_o(res_none_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int width_bits(input logic [1:0] es);
        return (es == 2'b00) ? 8 : (es == 2'b01) ? 16 : 32;
    endfunction

    // Expected {nar, none, result} from the requirements (R2, R3, R7-R10).
    function automatic logic [33:0] ref_op(input logic [VW-1:0] v, input logic [1:0] es,
                                           input logic z, input logic [VB-1:0] nr,
                                           input logic [VB-1:0] nn);
        int w;
        int n;
        logic [31:0] acc;
        logic [31:0] mask;
        logic rn;
        logic rnone;
        w = width_bits(es);
        n = VW / w;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        acc = 0;
        rn = 1'b0;
        rnone = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic isn;
            isn = nr[i] & nn[i];
            if (!(z && isn)) acc = acc + (32'(v >> (i * w)) & mask);
            if (isn && !z) rnone = 1'b1;
            if (nr[i] && !(z && isn)) rn = 1'b1;
        end
        return {rn, rnone, acc & mask};
    endfunction

    function automatic int stages(input logic [1:0] es);
        return (es == 2'b00) ? 4 : (es == 2'b01) ? 3 : 2;
    endfunction

    // One request; optionally fires a second start mid-sequence (R6).
    task automatic run_op(input logic [VW-1:0] v, input logic [1:0] es, input logic z,
                          input logic [VB-1:0] nr, input logic [VB-1:0] nn,
                          input logic inject, input string tag);
        logic [33:0] exp;
        int cnt;
        int s;
        exp = ref_op(v, es, z, nr, nn);
        s = stages(es);
        @(negedge clk);
        vec_i = v; esize_i = es; zero_none_i = z; lane_nar_i = nr; lane_none_i = nn;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        while (!done_o && cnt < 64) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                start_i = 1'b1; vec_i = ~v; esize_i = es ^ 2'b01; lane_nar_i = ~nr;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        // done is seen at the negedge following edge 2*s after the accepting edge
        check({"R4 latency ", tag}, 64'(cnt), 64'(2 * s + 1));
        check({"R3 result ", tag}, 64'(result_o), 64'(exp[31:0]));
        check({"R7 R8 meta ", tag}, 64'({res_nar_o, res_none_o}), 64'(exp[33:32]));
        @(negedge clk);
        check({"R5 pulse ", tag}, 64'(done_o), 64'd0);
        if (inject) begin
            for (int k = 0; k < 2 * s + 4; k++) begin
                @(negedge clk);
                if (done_o) check({"R6 no extra done ", tag}, 64'(done_o), 64'd0);
            end
            check({"R6 result kept ", tag}, 64'(result_o), 64'(exp[31:0]));
        end
    endtask

    initial begin
        int seed_init;
        logic [VW-1:0] rv;
        seed_init = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        check("R1 done low in reset", 64'(done_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done low after reset", 64'(done_o), 64'd0);

        // R2 R3: all-ones in each size; wraps
        run_op({VW{1'b1}}, 2'b00, 1'b0, '0, '0, 1'b0, "R2 ones8");
        run_op({VW{1'b1}}, 2'b01, 1'b0, '0, '0, 1'b0, "R2 ones16");
        run_op({VW{1'b1}}, 2'b10, 1'b0, '0, '0, 1'b0, "R2 ones32");
        run_op({VW{1'b1}}, 2'b11, 1'b0, '0, '0, 1'b0, "R2 ones reserved");
        // R3: lane index pattern
        for (int i = 0; i < VB; i++) rv[i*8 +: 8] = 8'(i + 1);
        run_op(rv, 2'b00, 1'b0, '0, '0, 1'b0, "R3 ramp8");
        run_op(rv, 2'b10, 1'b0, '0, '0, 1'b0, "R3 ramp32");
        // R7: None beats NaR
        run_op(rv, 2'b00, 1'b0, 16'h0011, 16'h0010, 1'b0, "R7 none wins");
        // R8: NaR alone; none payload alone is ordinary
        run_op(rv, 2'b01, 1'b0, 16'h0080, 16'h0000, 1'b0, "R8 nar");
        run_op(rv, 2'b01, 1'b0, 16'h0000, 16'hFFFF, 1'b0, "R8 payload only");
        // R9: metadata above lane 3 in 32-bit mode has no effect
        run_op(rv, 2'b10, 1'b0, 16'hFFF0, 16'hFF00, 1'b0, "R9 upper meta");
        run_op(rv, 2'b01, 1'b0, 16'hFF00, 16'hFF00, 1'b0, "R9 upper meta16");
        // R10: None lanes zeroed, NaR still poisons
        run_op(rv, 2'b00, 1'b1, 16'h0003, 16'h0001, 1'b0, "R10 zero with nar");
        run_op(rv, 2'b00, 1'b1, 16'h8001, 16'h8001, 1'b0, "R10 zero clean");
        // R6: start mid-sequence ignored
        run_op(rv, 2'b00, 1'b0, '0, '0, 1'b1, "R6 ignore8");
        run_op(rv, 2'b10, 1'b0, '0, '0, 1'b1, "R6 ignore32");
        // R5: outputs hold while idle with changing inputs
        begin
            logic [31:0] held;
            held = result_o;
            @(negedge clk);
            vec_i = '0; esize_i = 2'b01; lane_nar_i = '1; lane_none_i = '1;
            repeat (3) @(negedge clk);
            check("R5 result hold", 64'(result_o), 64'(held));
            check("R5 meta hold", 64'({res_nar_o, res_none_o}), 64'd0);
        end

        // Random mix
        for (int t = 0; t < 300; t++) begin
            logic [VB-1:0] nr;
            logic [VB-1:0] nn;
            for (int j = 0; j < VW / 32; j++) rv[j*32 +: 32] = $urandom;
            nr = ($urandom % 3 == 0) ? 16'($urandom & $urandom & $urandom) : '0;
            nn = 16'($urandom);
            run_op(rv, 2'($urandom), 1'($urandom), nr, nn, 1'($urandom % 8 == 0), "rand R3");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule